// File: doc/BRIEF.md
# Audio Coprocessor I/O Register Page

This block decodes the top sixteen byte locations of page zero in an audio coprocessor's 16-bit address space (0x00F0 to 0x00FF). It turns processor reads and writes there into register actions. These actions are three interval timers with 4-bit event counters, indirect access to the sound DSP's register file through a latched index, four host-to-coprocessor and four coprocessor-to-host mailbox bytes, and a small boot ROM. The boot ROM overlays the last 64 bytes of memory and can be switched off.

Every processor write is also passed to the external RAM at the same address, so RAM under the I/O page and under the ROM always holds the last value written. A read that does not hit a local register or the visible ROM goes to the RAM instead. Read data from either source appears on `cpu_rdata` in the cycle after the strobe.

The block also gives the DSP a one-cycle step pulse once every `STEP_PERIOD` clocks. All interfaces are plain strobes with no back-pressure, because every access completes in a fixed cycle. `cpu_rd` and `cpu_wr` are not expected high together; if they are, the write is performed and the read is dropped.

Top module: `aud_io_page`

## Requirements
- R1: After reset the ROM overlay is visible, the DSP index reads 0, all eight mailbox bytes are 0, every timer is disabled and every timer counter reads 0.
- R2: A write to 0x00F1 (the control byte) sets the timer enables from bits 0..2, where bit g is timer g, and sets ROM visibility from bit 7. A timer whose enable goes from 0 to 1 has its divider and counter cleared. A write that keeps an already set enable at 1 clears nothing.
- R3: In that control write, bit 4 clears the input mailbox bytes 0 and 1, and bit 5 clears input bytes 2 and 3. A clear wins over a host write to the same byte in the same cycle.
- R4: A write to 0x00F2 latches an 8-bit DSP index, and a read of 0x00F2 returns it unchanged.
- R5: Accesses to 0x00F3 reach the DSP register selected by the low 7 bits of the index (`dsp_reg_addr`). A write there raises `dsp_reg_we` only when index bit 7 is 0.
- R6: A processor write to 0x00F4+i (i = 0..3) stores output byte i, shown on `mbox_out[8i+7:8i]`. A read of 0x00F4+i returns input byte i, last written by the host with `host_sel` = i.
- R7: Reads of 0x00F0, 0x00F1 and 0x00FA..0x00FC return 0. A write to 0x00FA+g sets the 8-bit target of timer g.
- R8: Timers 0 and 1 tick every `SLOW_DIV` clocks and timer 2 every `FAST_DIV` clocks. Ticks fall on the edges whose count since reset is a multiple of the divide. On each tick an enabled timer increments its divider. When the divider reaches the target, where a target of 0 means 256, the divider returns to 0 and the 4-bit counter increments modulo 16.
- R9: A read of 0x00FD+g returns the counter of timer g in bits 3..0, with zeros above, and clears it. A counter increment in the same cycle as that read leaves the counter at 1.
- R10: While the ROM is visible, reads of 0xFFC0..0xFFFF return byte (address - 0xFFC0) of `BOOT_IMAGE`. While it is hidden, those reads go to RAM.
- R11: Every processor write drives `ram_we`, `ram_addr` and `ram_wdata` in the same cycle, including writes to the I/O page and the ROM area. Reads other than local registers and visible ROM, including 0x00F8 and 0x00F9, raise `ram_re` and return `ram_rdata`.
- R12: Read data appears on `cpu_rdata` in the cycle after the strobe. A counter is cleared only by a read strobe, not by the address merely resting on it.
- R13: `dsp_step` is high for one cycle out of every `STEP_PERIOD`, first in the cycle that follows reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable; RAM returns data next cycle |
| ram_rdata | input | 8 | RAM read data |
| dsp_reg_addr | output | 7 | DSP register index |
| dsp_reg_wdata | output | 8 | DSP register write data |
| dsp_reg_we | output | 1 | DSP register write enable |
| dsp_reg_rdata | input | 8 | DSP register read data for `dsp_reg_addr` |
| dsp_step | output | 1 | DSP step pulse |
| host_we | input | 1 | Host write to an input mailbox byte |
| host_sel | input | 2 | Input mailbox byte selected by the host |
| host_wdata | input | 8 | Host mailbox data |
| mbox_out | output | 32 | Output mailbox bytes, byte i at bits 8i+7..8i |

## Verification
The bench builds the block with `SLOW_DIV` = 8, `FAST_DIV` = 4, `STEP_PERIOD` = 8 and a boot image of its own. With these values a run sweeps every timer through targets 1, 2, 3, 5 and 256 within a few thousand clocks. The counter values follow from a closed form over the tick edges, so reads that land on a tick edge, restarts, re-enables and disables all fall in reach. The same build lets the bench read all 64 ROM bytes one by one.

// File: rtl/aud_io_pkg.sv
package aud_io_pkg;

  localparam int ROM_BYTES = 64;
  localparam int ROM_AW    = $clog2(ROM_BYTES);

  // Offsets within the 0x00F0 page (low nibble)
  localparam logic [3:0] OFS_CTRL  = 4'h1;
  localparam logic [3:0] OFS_DIDX  = 4'h2;
  localparam logic [3:0] OFS_DDAT  = 4'h3;
  localparam logic [3:0] OFS_MBOX  = 4'h4;
  localparam logic [3:0] OFS_SPR0  = 4'h8;
  localparam logic [3:0] OFS_SPR1  = 4'h9;
  localparam logic [3:0] OFS_TGT   = 4'hA;
  localparam logic [3:0] OFS_CNT   = 4'hD;

  // Control byte field positions
  localparam int CTL_CLR_LO = 4;
  localparam int CTL_CLR_HI = 5;
  localparam int CTL_ROM    = 7;

  typedef enum logic {SRC_LOCAL, SRC_RAM} rd_src_e;

  function automatic logic [ROM_BYTES*8-1:0] boot_image_default();
    logic [ROM_BYTES*8-1:0] img;
    for (int i = 0; i < ROM_BYTES; i++) begin
      img[i*8 +: 8] = 8'(i * 29 + 65) ^ 8'(i >> 2);
    end
    return img;
  endfunction

endpackage

// File: rtl/aud_io_timer.sv
module aud_io_timer #(
  parameter int DIV   = 128,
  parameter int TGT_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [TGT_W-1:0] target,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] count
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DIV - 1);

  logic [PW-1:0]    presc_q;
  logic             tick;
  logic [TGT_W-1:0] div_q, div_nx;
  logic             bump;

  assign tick = (presc_q == PLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    presc_q <= '0;
    else if (tick) presc_q <= '0;
    else           presc_q <= presc_q + 1'b1;
  end

  always_comb begin
    div_nx = div_q + 1'b1;
    bump   = run && tick && (div_nx == target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           div_q <= '0;
    else if (restart)     div_q <= '0;
    else if (run && tick) div_q <= bump ? '0 : div_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else if (rd_clr)  count <= CNT_W'(bump);
    else if (bump)    count <= count + 1'b1;
  end
endmodule

// File: rtl/aud_io_mailbox.sv
module aud_io_mailbox #(
  parameter int PORTS = 4,
  parameter int W     = 8,
  localparam int SW   = $clog2(PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [SW-1:0]     cpu_sel,
  input  logic [W-1:0]      cpu_wdata,
  input  logic              host_we,
  input  logic [SW-1:0]     host_sel,
  input  logic [W-1:0]      host_wdata,
  input  logic              clr_lo,
  input  logic              clr_hi,
  output logic [PORTS*W-1:0] in_flat,
  output logic [PORTS*W-1:0] out_flat
);
  for (genvar i = 0; i < PORTS; i++) begin : g_port
    logic clr;
    assign clr = (i < PORTS / 2) ? clr_lo : clr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   in_flat[i*W +: W] <= '0;
      else if (clr)                                 in_flat[i*W +: W] <= '0;
      else if (host_we && host_sel == SW'(i))       in_flat[i*W +: W] <= host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   out_flat[i*W +: W] <= '0;
      else if (cpu_we && cpu_sel == SW'(i))         out_flat[i*W +: W] <= cpu_wdata;
    end
  end
endmodule

// File: rtl/aud_io_stepper.sv
module aud_io_stepper #(
  parameter int PERIOD = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic step
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] CLAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q == CLAST) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign step = (cnt_q == '0);
endmodule

// File: rtl/aud_io_page.sv
module aud_io_page
  import aud_io_pkg::*;
#(
  parameter int SLOW_DIV    = 128,
  parameter int FAST_DIV    = 16,
  parameter int STEP_PERIOD = 32,
  parameter logic [ROM_BYTES*8-1:0] BOOT_IMAGE = boot_image_default()
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  output logic [7:0]  cpu_rdata,
  output logic [15:0] ram_addr,
  output logic [7:0]  ram_wdata,
  output logic        ram_we,
  output logic        ram_re,
  input  logic [7:0]  ram_rdata,
  output logic [6:0]  dsp_reg_addr,
  output logic [7:0]  dsp_reg_wdata,
  output logic        dsp_reg_we,
  input  logic [7:0]  dsp_reg_rdata,
  output logic        dsp_step,
  input  logic        host_we,
  input  logic [1:0]  host_sel,
  input  logic [7:0]  host_wdata,
  output logic [31:0] mbox_out
);
  localparam int NTMR  = 3;
  localparam int NMBOX = 4;
  localparam int CNT_W = 4;
  localparam logic [15:0] ROM_BASE = 16'(65536 - ROM_BYTES);

  logic       rd_go;
  logic       io_page;
  logic [3:0] ofs;
  logic       rom_hit;
  logic       io_local;
  logic       ctl_we;

  logic [NTMR-1:0] en_q;
  logic            rom_vis_q;
  logic [7:0]      dsp_lat_q;
  logic [NMBOX*8-1:0] mbox_in_flat;

  logic [NTMR-1:0]       tmr_restart;
  logic [NTMR-1:0]       tmr_rdclr;
  logic [CNT_W*NTMR-1:0] tmr_cnt;

  logic [7:0] rd_val;
  logic [7:0] rdata_q;
  rd_src_e    src_q;

  // ---------------- decode ----------------
  assign rd_go    = cpu_rd && !cpu_wr;
  assign io_page  = (cpu_addr[15:4] == 12'h00F);
  assign ofs      = cpu_addr[3:0];
  assign rom_hit  = rom_vis_q && (cpu_addr >= ROM_BASE);
  assign io_local = io_page && (ofs != OFS_SPR0) && (ofs != OFS_SPR1);
  assign ctl_we   = cpu_wr && io_page && (ofs == OFS_CTRL);

  // ---------------- RAM side ----------------
  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;
  assign ram_we    = cpu_wr;
  assign ram_re    = rd_go && !rom_hit && !io_local;

  // ---------------- control byte ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      rom_vis_q <= 1'b1;
    end else if (ctl_we) begin
      en_q      <= cpu_wdata[NTMR-1:0];
      rom_vis_q <= cpu_wdata[CTL_ROM];
    end
  end

  // ---------------- DSP indirect access ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    dsp_lat_q <= '0;
    else if (cpu_wr && io_page && ofs == OFS_DIDX) dsp_lat_q <= cpu_wdata;
  end

  assign dsp_reg_addr  = dsp_lat_q[6:0];
  assign dsp_reg_wdata = cpu_wdata;
  assign dsp_reg_we    = cpu_wr && io_page && (ofs == OFS_DDAT) && !dsp_lat_q[7];

  aud_io_stepper #(.PERIOD(STEP_PERIOD)) u_step (
    .clk  (clk),
    .rst_n(rst_n),
    .step (dsp_step)
  );

  // ---------------- mailboxes ----------------
  logic mbox_we;
  assign mbox_we = cpu_wr && io_page && (ofs[3:2] == OFS_MBOX[3:2]);

  aud_io_mailbox #(.PORTS(NMBOX), .W(8)) u_mbox (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (mbox_we),
    .cpu_sel   (ofs[1:0]),
    .cpu_wdata (cpu_wdata),
    .host_we   (host_we),
    .host_sel  (host_sel),
    .host_wdata(host_wdata),
    .clr_lo    (ctl_we && cpu_wdata[CTL_CLR_LO]),
    .clr_hi    (ctl_we && cpu_wdata[CTL_CLR_HI]),
    .in_flat   (mbox_in_flat),
    .out_flat  (mbox_out)
  );

  // ---------------- timers ----------------
  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    logic [7:0] tgt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          tgt_q <= '0;
      else if (cpu_wr && io_page && ofs == OFS_TGT + 4'(g)) tgt_q <= cpu_wdata;
    end

    assign tmr_restart[g] = ctl_we && cpu_wdata[g] && !en_q[g];
    assign tmr_rdclr[g]   = rd_go && io_page && (ofs == OFS_CNT + 4'(g));

    aud_io_timer #(
      .DIV  ((g == NTMR - 1) ? FAST_DIV : SLOW_DIV),
      .TGT_W(8),
      .CNT_W(CNT_W)
    ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (en_q[g]),
      .restart(tmr_restart[g]),
      .target (tgt_q),
      .rd_clr (tmr_rdclr[g]),
      .count  (tmr_cnt[g*CNT_W +: CNT_W])
    );
  end

  // ---------------- read path ----------------
  always_comb begin
    rd_val = '0;
    if (rom_hit) begin
      rd_val = BOOT_IMAGE[cpu_addr[ROM_AW-1:0]*8 +: 8];
    end else if (io_page) begin
      if (ofs == OFS_DIDX) rd_val = dsp_lat_q;
      if (ofs == OFS_DDAT) rd_val = dsp_reg_rdata;
      for (int i = 0; i < NMBOX; i++) begin
        if (ofs == OFS_MBOX + 4'(i)) rd_val = mbox_in_flat[i*8 +: 8];
      end
      for (int g = 0; g < NTMR; g++) begin
        if (ofs == OFS_CNT + 4'(g)) rd_val = 8'(tmr_cnt[g*CNT_W +: CNT_W]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      src_q   <= SRC_LOCAL;
    end else if (rd_go) begin
      rdata_q <= rd_val;
      src_q   <= ram_re ? SRC_RAM : SRC_LOCAL;
    end
  end

  assign cpu_rdata = (src_q == SRC_RAM) ? ram_rdata : rdata_q;
endmodule

// File: rtl/aud_io_page_chk.sv
module aud_io_page_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic        dsp_reg_we,
  input logic        dsp_step,
  input logic        ram_re,
  input logic [7:0]  dsp_lat,
  input logic        rom_vis,
  input logic [31:0] mbox_in
);
  // R5: a DSP write only ever comes from a processor write to the data location
  assert_dsp_we_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_reg_we |-> (cpu_wr && cpu_addr == 16'h00F3));

  // R4: index holds unless written
  assert_index_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr == 16'h00F2) |=> $stable(dsp_lat));

  // R3: low clear empties input bytes 0 and 1
  assert_clear_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F1 && cpu_wdata[4]) |=> (mbox_in[15:0] == 16'h0));

  // R3: high clear empties input bytes 2 and 3
  assert_clear_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F1 && cpu_wdata[5]) |=> (mbox_in[31:16] == 16'h0));

  // R2: control bit 7 sets ROM visibility
  assert_rom_vis_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F1) |=> (rom_vis == $past(cpu_wdata[7])));

  // R11: RAM is only read on a read strobe
  assert_ram_re_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> (cpu_rd && !cpu_wr));

  // R13: step never lasts two cycles
  assert_step_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_step |=> !dsp_step);
endmodule

bind aud_io_page aud_io_page_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .dsp_reg_we(dsp_reg_we),
  .dsp_step  (dsp_step),
  .ram_re    (ram_re),
  .dsp_lat   (dsp_lat_q),
  .rom_vis   (rom_vis_q),
  .mbox_in   (mbox_in_flat)
);

// File: tb/tb_aud_io_page.sv
`timescale 1ns/1ps
module tb_aud_io_page;
  localparam int PS   = 8;   // slow divide
  localparam int PF   = 4;   // fast divide
  localparam int STEP = 8;

  function automatic logic [511:0] tb_image();
    logic [511:0] m;
    for (int i = 0; i < 64; i++) m[i*8 +: 8] = 8'(i * 7) ^ 8'hC3;
    return m;
  endfunction

  function automatic logic [7:0] ram_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic int incs(input int e, input int r, input int p, input int t);
    int n;
    n = (r - 1) / p - e / p;
    return n / ((t == 0) ? 256 : t);
  endfunction

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic        cpu_rd = 0, cpu_wr = 0;
  logic [7:0]  cpu_rdata;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        ram_we, ram_re;
  logic [6:0]  dsp_reg_addr;
  logic [7:0]  dsp_reg_wdata, dsp_reg_rdata;
  logic        dsp_reg_we, dsp_step;
  logic        host_we = 0;
  logic [1:0]  host_sel = 0;
  logic [7:0]  host_wdata = 0;
  logic [31:0] mbox_out;

  always #2 clk = ~clk;  // 250 MHz

  aud_io_page #(.SLOW_DIV(PS), .FAST_DIV(PF), .STEP_PERIOD(STEP), .BOOT_IMAGE(tb_image())) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
    .ram_rdata(ram_rdata), .dsp_reg_addr(dsp_reg_addr), .dsp_reg_wdata(dsp_reg_wdata),
    .dsp_reg_we(dsp_reg_we), .dsp_reg_rdata(dsp_reg_rdata), .dsp_step(dsp_step),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata), .mbox_out(mbox_out)
  );

  // RAM and DSP models
  logic [7:0] ram_q = 0;
  always @(posedge clk) if (ram_re) ram_q <= ram_val(ram_addr);
  assign ram_rdata     = ram_q;
  assign dsp_reg_rdata = {1'b1, dsp_reg_addr} ^ 8'h33;

  int ecnt = 0;
  always @(posedge clk) ecnt <= rst_n ? ecnt + 1 : 0;

  int n_run = 0, n_fail = 0;
  logic dsp_seen;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, output int e);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1; #1;
    chk("R11 write reaches RAM", {7'b0, ram_we, ram_addr, ram_wdata}, {7'b0, 1'b1, a, d});
    dsp_seen = dsp_reg_we;
    e = ecnt + 1;
    @(posedge clk); @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic wr0(input logic [15:0] a, input logic [7:0] d);
    int e;
    wr(a, d, e);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v, output int e);
    cpu_addr = a; cpu_rd = 1;
    e = ecnt + 1;
    @(posedge clk); @(negedge clk);
    cpu_rd = 0;
    v = cpu_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v; int e;
    rd(a, v, e);
    chk(tag, {24'b0, v}, {24'b0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int e, r1, r2, r3, d, p;
    logic [7:0] img [64];
    for (int i = 0; i < 64; i++) img[i] = 8'(i * 7) ^ 8'hC3;

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R13 step pulse, sampled from the first cycle after reset
    for (int i = 0; i < 24; i++) begin
      chk("R13 step", {31'b0, dsp_step}, {31'b0, 1'(ecnt % STEP == 0)});
      @(negedge clk);
    end

    // R1 reset state
    chk("R1 mbox_out reset", mbox_out, 32'h0);
    rd_chk("R1 index reset", 16'h00F2, 8'h00);
    for (int i = 0; i < 4; i++) rd_chk("R1 input byte reset", 16'(16'h00F4 + i), 8'h00);
    for (int g = 0; g < 3; g++) rd_chk("R1 counter reset", 16'(16'h00FD + g), 8'h00);
    rd_chk("R1 ROM visible at reset", 16'hFFC0, img[0]);

    // R10 full ROM sweep, R12 one-cycle data
    for (int i = 0; i < 64; i++) rd_chk("R10 R12 ROM byte", 16'(16'hFFC0 + i), img[i]);
    wr0(16'hFFC3, 8'h99);  // R11 write under visible ROM still reaches RAM
    rd_chk("R10 ROM unaffected by write", 16'hFFC3, img[3]);

    // R4 index readback, R5 DSP access
    wr0(16'h00F2, 8'hA5);
    rd_chk("R4 index readback", 16'h00F2, 8'hA5);
    rd_chk("R5 DSP read low 7 bits", 16'h00F3, {1'b1, 7'h25} ^ 8'h33);
    wr0(16'h00F3, 8'h11);
    chk("R5 write suppressed for index>=0x80", {31'b0, dsp_seen}, 32'h0);
    wr0(16'h00F2, 8'h15);
    wr0(16'h00F3, 8'h22);
    chk("R5 write passes for index<0x80", {31'b0, dsp_seen}, 32'h1);
    rd_chk("R5 DSP read", 16'h00F3, {1'b1, 7'h15} ^ 8'h33);

    // R7 zero reads
    wr0(16'h00FA, 8'h07);
    foreach (img[i]) if (i < 1) begin end
    rd_chk("R7 F0 reads zero", 16'h00F0, 8'h00);
    rd_chk("R7 F1 reads zero", 16'h00F1, 8'h00);
    for (int g = 0; g < 3; g++) rd_chk("R7 target reads zero", 16'(16'h00FA + g), 8'h00);

    // R6 mailboxes
    for (int i = 0; i < 4; i++) wr0(16'(16'h00F4 + i), 8'(8'h10 * (i + 1) + i));
    chk("R6 mbox_out", mbox_out, 32'h43_32_21_10);
    for (int i = 0; i < 4; i++) begin
      host_we = 1; host_sel = 2'(i); host_wdata = 8'(8'hB0 + i);
      @(negedge clk);
    end
    host_we = 0;
    for (int i = 0; i < 4; i++) rd_chk("R6 input byte", 16'(16'h00F4 + i), 8'(8'hB0 + i));

    // R3 clears, with host write to byte 0 in the same cycle
    host_we = 1; host_sel = 0; host_wdata = 8'hEE;
    wr0(16'h00F1, 8'h90);
    host_we = 0;
    rd_chk("R3 clear beats host write", 16'h00F4, 8'h00);
    rd_chk("R3 low clear byte1", 16'h00F5, 8'h00);
    rd_chk("R3 high bytes kept", 16'h00F6, 8'hB2);
    wr0(16'h00F1, 8'hA0);
    rd_chk("R3 high clear byte3", 16'h00F7, 8'h00);
    chk("R6 output bytes untouched by clear", mbox_out, 32'h43_32_21_10);

    // R11 RAM reads
    rd_chk("R11 RAM at F8", 16'h00F8, ram_val(16'h00F8));
    rd_chk("R11 RAM at F9", 16'h00F9, ram_val(16'h00F9));
    rd_chk("R11 RAM at EF", 16'h00EF, ram_val(16'h00EF));
    rd_chk("R11 RAM at 1234", 16'h1234, ram_val(16'h1234));

    // R2 ROM hidden -> RAM (R10)
    wr0(16'h00F1, 8'h00);
    rd_chk("R2 R10 ROM hidden", 16'hFFC5, ram_val(16'hFFC5));
    rd_chk("R10 ROM hidden last byte", 16'hFFFF, ram_val(16'hFFFF));
    wr0(16'h00F1, 8'h80);
    rd_chk("R2 ROM visible again", 16'hFFFF, img[63]);

    // Timer sweep: R8, R9, R2 restart/no-restart, R12 address resting
    for (int t = 0; t < 3; t++) begin
      p = (t == 2) ? PF : PS;
      for (int k = 0; k < 5; k++) begin
        int tg;
        tg = (k == 4) ? 0 : ((k == 3) ? 5 : k + 1);
        wr0(16'(16'h00FA + t), 8'(tg));
        wr0(16'h00F1, 8'h80);
        wr(16'h00F1, 8'(8'h80 | (1 << t)), e);
        idle(9 + t * 5 + tg);
        rd(16'(16'h00FD + t), v, r1);
        chk("R8 first count", {24'b0, v}, 32'(incs(e, r1, p, tg) % 16));
        wr0(16'h00F1, 8'(8'h80 | (1 << t)));  // R2: held enable does not restart
        cpu_addr = 16'(16'h00FD + t);          // R12: address rests, no strobe
        idle((tg == 0) ? 2100 : 13 + tg * 3);
        rd(16'(16'h00FD + t), v, r2);
        chk("R9 R12 count after clearing read", {24'b0, v},
            32'((incs(e, r2, p, tg) - incs(e, r1, p, tg)) % 16));
        wr(16'h00F1, 8'h80, d);
        idle(30);
        rd(16'(16'h00FD + t), v, r3);
        chk("R2 disable freezes count", {24'b0, v},
            32'((incs(e, d + 1, p, tg) - incs(e, r2, p, tg)) % 16));
        rd_chk("R9 read clears", 16'(16'h00FD + t), 8'h00);
      end
    end

    // R2 re-enable clears a stale counter: run timer 2 target 1, disable, re-enable
    wr0(16'h00FC, 8'h01);
    wr0(16'h00F1, 8'h84);
    idle(20);
    wr0(16'h00F1, 8'h80);
    wr(16'h00F1, 8'h84, e);
    rd(16'h00FF, v, r1);
    chk("R2 restart clears counter", {24'b0, v}, 32'(incs(e, r1, PF, 1) % 16));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule